// File: doc/BRIEF.md
# Link Self-Test Pattern Checker

This block sits behind the line decoder of a serial receiver and checks a repeating test sequence that a matching transmitter-side generator sends over the link. While the active-low self-test enable is held low, the checker hunts for the loop marker, a plain data byte of value 0x00. Once it finds the marker, it compares every following strobed byte against a locally generated copy of the sequence. Each byte's verdict goes to the violation output: low for a byte that matches and high for one that does not. The sync output drops for one byte time on the last byte of each 256-byte loop.

While the enable is high, the checker is idle and forwards the receiver's normal status: the code-violation flag goes to the violation output and the upstream sync indication goes to the sync output. Both outputs are registered and change only on a cycle in which the byte strobe is high. Reset is synchronous and active high.

Top module: `link_selftest_checker`

## Requirements
- R1: While reset is high at a clock edge, the violation output and the sync output are both driven low, and the checker returns to hunting for the marker.
- R2: While `test_en_n` is high, each strobed byte copies `rx_cviol` to `viol_o` and `sync_in` to `sync_o` at the clock edge that samples the strobe, and the checker returns to hunting.
- R3: While hunting in test mode, every strobed byte that is not the marker drives `viol_o` high and `sync_o` high. The marker is data 0x00 with `rx_special` low and `rx_cviol` low.
- R4: When a marker arrives while hunting, `viol_o` goes low and `sync_o` goes high, and the next byte is compared with loop index 1.
- R5: The expected byte at loop index 0 is 0x00. Index 1 is 0x01, and every later index k+1 is {s[6:0], s[7]^s[5]^s[4]^s[3]}, where s is the byte at index k. After index 255 the loop wraps to index 0.
- R6: While tracking, `viol_o` is low for a byte equal to the expected value and high for any other byte. The loop position advances by one for every strobed byte, whether or not it matches.
- R7: While tracking, a byte with `rx_special` high or `rx_cviol` high counts as a mismatch (`viol_o` high), even when its data equals the expected value.
- R8: While tracking, `sync_o` is low for the byte at loop index 255 and high for every other byte.
- R9: A marker received while tracking at any index other than 0 drives `viol_o` high and `sync_o` high, and resets the position so that the next byte is compared with index 1.
- R10: On a cycle with `byte_vld` low, both outputs keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| test_en_n | input | 1 | Self-test enable, active low |
| byte_vld | input | 1 | Strobe: a decoded byte is present this cycle |
| rx_data | input | 8 | Decoded byte |
| rx_special | input | 1 | Byte is a special (control) character |
| rx_cviol | input | 1 | Decoder found a code-rule violation on this byte |
| sync_in | input | 1 | Normal-mode sync indication, forwarded when not testing |
| viol_o | output | 1 | Per-byte fail flag in test mode; violation status otherwise |
| sync_o | output | 1 | Loop-end marker (low for one byte) in test mode; forwarded sync otherwise |

## Verification
Two functions can report on the same byte: the end-of-loop indication on `sync_o` and the mismatch verdict on `viol_o`. Both can also meet the resynchronising marker. The bench sends a corrupted byte, and separately a byte flagged as special, at loop index 255. In each case it expects `viol_o` high and `sync_o` low in the same cycle, and then expects the next loop to start cleanly. It also sends a marker at index 255 and expects resynchronisation to take priority: `sync_o` stays high, `viol_o` goes high, and the following byte is accepted as index 1. The bench walks complete 256-byte loops and computes every expected byte from the recurrence.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

    localparam int BYTE_W = 8;
    localparam int LOOP_LEN = 1 << BYTE_W;
    // feedback taps for x^8+x^6+x^5+x^4+1, applied to a left-shifting register
    localparam logic [BYTE_W-1:0] LFSR_TAPS = 8'b1011_1000;
    localparam logic [BYTE_W-1:0] LFSR_FIRST = 8'h01;
    localparam logic [BYTE_W-1:0] MARK_BYTE = '0;

    typedef enum logic {
        CHK_HUNT  = 1'b0,
        CHK_TRACK = 1'b1
    } chk_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              special;
        logic              cviol;
    } rx_sym_t;

    typedef struct packed {
        logic viol;
        logic sync;
    } chk_out_t;

    function automatic logic [BYTE_W-1:0] lfsr_step(input logic [BYTE_W-1:0] s);
        return {s[BYTE_W-2:0], ^(s & LFSR_TAPS)};
    endfunction

    function automatic logic is_marker(input rx_sym_t sym);
        return (sym.data == MARK_BYTE) && !sym.special && !sym.cviol;
    endfunction

endpackage

// File: rtl/lbc_pattern_gen.sv
module lbc_pattern_gen
    import lbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              advance,
    output logic [BYTE_W-1:0] exp_byte,
    output logic              at_start,
    output logic              at_last
);

    logic [BYTE_W-1:0] pos_q;
    logic [BYTE_W-1:0] lfsr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            lfsr_q <= LFSR_FIRST;
        end else if (restart) begin
            pos_q  <= BYTE_W'(1);
            lfsr_q <= LFSR_FIRST;
        end else if (advance) begin
            pos_q <= pos_q + 1'b1;
            if (pos_q != '0) begin
                lfsr_q <= lfsr_step(lfsr_q);
            end
        end
    end

    assign at_start = (pos_q == '0);
    assign at_last  = &pos_q;
    assign exp_byte = at_start ? MARK_BYTE : lfsr_q;

    // R5: a maximal-length register never reaches the all-zero state
    p_lfsr_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

    // R5: the marker position always expects the zero byte, and no later position does
    p_zero_only_at_start_r5: assert property (@(posedge clk) disable iff (rst)
        (exp_byte == '0) |-> at_start);

endmodule

// File: rtl/lbc_verdict.sv
module lbc_verdict
    import lbc_pkg::*;
(
    input  rx_sym_t           sym,
    input  logic [BYTE_W-1:0] exp_byte,
    output logic              mismatch
);

    always_comb begin
        mismatch = (sym.data != exp_byte) || sym.special || sym.cviol;
    end

endmodule

// File: rtl/link_selftest_checker.sv
module link_selftest_checker
    import lbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              test_en_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_special,
    input  logic              rx_cviol,
    input  logic              sync_in,
    output logic              viol_o,
    output logic              sync_o
);

    rx_sym_t           sym;
    chk_state_e        state_q;
    chk_out_t          out_q;
    logic [BYTE_W-1:0] exp_byte;
    logic              at_start;
    logic              at_last;
    logic              mismatch;
    logic              marker;
    logic              testing;
    logic              gen_restart;
    logic              gen_advance;

    assign sym     = '{data: rx_data, special: rx_special, cviol: rx_cviol};
    assign marker  = is_marker(sym);
    assign testing = byte_vld && !test_en_n;

    // a marker restarts the pattern from hunt or from any position but the loop start
    assign gen_restart = testing && marker && ((state_q == CHK_HUNT) || !at_start);
    assign gen_advance = testing && (state_q == CHK_TRACK) && !gen_restart;

    lbc_pattern_gen gen_i (
        .clk      (clk),
        .rst      (rst),
        .restart  (gen_restart),
        .advance  (gen_advance),
        .exp_byte (exp_byte),
        .at_start (at_start),
        .at_last  (at_last)
    );

    lbc_verdict verdict_i (
        .sym      (sym),
        .exp_byte (exp_byte),
        .mismatch (mismatch)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CHK_HUNT;
            out_q   <= '{viol: 1'b0, sync: 1'b0};
        end else if (byte_vld) begin
            if (test_en_n) begin
                state_q <= CHK_HUNT;
                out_q   <= '{viol: rx_cviol, sync: sync_in};
            end else if (state_q == CHK_HUNT) begin
                if (marker) begin
                    state_q <= CHK_TRACK;
                    out_q   <= '{viol: 1'b0, sync: 1'b1};
                end else begin
                    out_q   <= '{viol: 1'b1, sync: 1'b1};
                end
            end else if (gen_restart) begin
                out_q <= '{viol: 1'b1, sync: 1'b1};
            end else begin
                out_q <= '{viol: mismatch, sync: !at_last};
            end
        end
    end

    assign viol_o = out_q.viol;
    assign sync_o = out_q.sync;

    // R10: outputs hold on cycles without a byte
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !byte_vld |=> ($stable(viol_o) && $stable(sync_o)));

    // R2: pass-through of normal status outside test mode
    p_pass_through_r2: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && test_en_n) |=> (viol_o == $past(rx_cviol)) && (sync_o == $past(sync_in)));

    // R3: while hunting, non-marker bytes fail and sync stays high
    p_hunt_fail_r3: assert property (@(posedge clk) disable iff (rst)
        (testing && state_q == CHK_HUNT && !marker) |=> (viol_o && sync_o));

    // R7: flagged bytes always fail while tracking
    p_flag_fail_r7: assert property (@(posedge clk) disable iff (rst)
        (testing && state_q == CHK_TRACK && (rx_special || rx_cviol)) |=> viol_o);

    // R8: the loop-end byte drops sync unless a marker resynchronises
    p_loop_end_r8: assert property (@(posedge clk) disable iff (rst)
        (testing && state_q == CHK_TRACK && at_last && !marker) |=> !sync_o);

    // R9: a marker away from the loop start fails and restarts at index 1
    p_resync_r9: assert property (@(posedge clk) disable iff (rst)
        (testing && state_q == CHK_TRACK && marker && !at_start)
            |=> (viol_o && sync_o && exp_byte == LFSR_FIRST));

endmodule

// File: tb/link_selftest_checker_tb_top.sv
`timescale 1ns/1ps
module link_selftest_checker_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       test_en_n;
    logic       byte_vld;
    logic [7:0] rx_data;
    logic       rx_special;
    logic       rx_cviol;
    logic       sync_in;
    logic       viol_o;
    logic       sync_o;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [7:0] pat [256];

    always #2 clk = ~clk;

    link_selftest_checker dut_i (
        .clk(clk), .rst(rst), .test_en_n(test_en_n), .byte_vld(byte_vld),
        .rx_data(rx_data), .rx_special(rx_special), .rx_cviol(rx_cviol),
        .sync_in(sync_in), .viol_o(viol_o), .sync_o(sync_o)
    );

    task automatic check(input string req, input logic ev, input logic es);
        total++;
        if (viol_o !== ev || sync_o !== es) begin
            bad++;
            $display("FAIL %s: viol=%b sync=%b expected viol=%b sync=%b", req, viol_o, sync_o, ev, es);
        end
    endtask

    // one strobed byte: drive at a falling edge, sample at the next falling edge
    task automatic put(input logic [7:0] d, input logic sp, input logic cv, input logic si);
        @(negedge clk);
        rx_data = d; rx_special = sp; rx_cviol = cv; sync_in = si; byte_vld = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic put_chk(input string req, input logic [7:0] d, input logic sp,
                           input logic cv, input logic ev, input logic es);
        put(d, sp, cv, 1'b0);
        check(req, ev, es);
    endtask

    // clean bytes from index a to index b of the loop
    task automatic run_span(input int a, input int b);
        for (int i = a; i <= b; i++) begin
            put_chk((i == 255) ? "R8 loop end" : "R5/R6 sequence", pat[i], 1'b0, 1'b0, 1'b0, (i != 255));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] s;
        pat[0] = 8'h00;
        s = 8'h01;
        for (int k = 1; k < 256; k++) begin
            pat[k] = s;
            s = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
        end

        rst = 1'b1; test_en_n = 1'b1; byte_vld = 1'b0;
        rx_data = 8'h00; rx_special = 1'b0; rx_cviol = 1'b0; sync_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0, 1'b0);
        rst = 1'b0;

        // R2 pass-through, all four combinations
        for (int c = 0; c < 4; c++) begin
            put(8'hA5, 1'b0, c[0], c[1]);
            check("R2 pass-through", c[0], c[1]);
        end
        // R10 idle cycles with moving inputs
        rx_cviol = 1'b0; sync_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 hold idle", 1'b1, 1'b1);
        test_en_n = 1'b0;
        rx_data = 8'h00;
        repeat (2) @(negedge clk);
        check("R10 hold idle test", 1'b1, 1'b1);

        // R3 hunting
        put_chk("R3 hunt data", 8'h55, 1'b0, 1'b0, 1'b1, 1'b1);
        put_chk("R3 hunt special zero", 8'h00, 1'b1, 1'b0, 1'b1, 1'b1);
        put_chk("R3 hunt cviol zero", 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
        put_chk("R3 hunt one", 8'h01, 1'b0, 1'b0, 1'b1, 1'b1);

        // R4 marker then two full loops
        put_chk("R4 marker in hunt", 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        run_span(1, 255);
        put_chk("R5 wrap marker", 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        run_span(1, 255);

        // R6/R7 errors inside a loop
        put_chk("R5 marker", 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        run_span(1, 9);
        put_chk("R6 wrong byte", pat[10] ^ 8'h10, 1'b0, 1'b0, 1'b1, 1'b1);
        run_span(11, 19);
        put_chk("R7 special flag", pat[20], 1'b1, 1'b0, 1'b1, 1'b1);
        put_chk("R7 cviol flag", pat[21], 1'b0, 1'b1, 1'b1, 1'b1);
        run_span(22, 254);
        // mismatch on the loop-end byte: both outputs report
        put_chk("R6/R8 mismatch at end", pat[255] ^ 8'h01, 1'b0, 1'b0, 1'b1, 1'b0);
        put_chk("R5 marker", 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        run_span(1, 254);
        put_chk("R7/R8 special at end", pat[255], 1'b1, 1'b0, 1'b1, 1'b0);

        // R9 unexpected marker mid-loop
        put_chk("R5 marker", 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        run_span(1, 49);
        put_chk("R9 stray marker", 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
        run_span(1, 254);
        // R9 marker at index 255 takes priority over loop end
        put_chk("R9 marker at end", 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
        run_span(1, 3);

        // R2 leaving test mode, then R3 hunting again
        test_en_n = 1'b1;
        put(pat[4], 1'b0, 1'b0, 1'b1);
        check("R2 exit test", 1'b0, 1'b1);
        test_en_n = 1'b0;
        put_chk("R3 rehunt", pat[5], 1'b0, 1'b0, 1'b1, 1'b1);
        put_chk("R4 marker again", 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        run_span(1, 5);

        // R1 reset mid-loop
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 reset mid-loop", 1'b0, 1'b0);
        put_chk("R1/R3 hunting after reset", pat[6], 1'b0, 1'b0, 1'b1, 1'b1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule